// File: doc/BRIEF.md
# Network Activity LED Combiner

This block drives four active-low indicator pins from eight network status signals. Each pin has its own configuration word. The word holds one enable bit for every status source, plus one bit that selects the display path. The enabled sources for a pin are ORed into one combined indication. That indication drives the pin either directly (raw path) or through a pulse stretcher. The stretcher keeps a short event visible for two to three periods of a slow tick.

The slow tick comes from a divider on the system clock. The `TICK_DIV` parameter sets the divide ratio. The default gives about 38 Hz from a 125 MHz clock, and a small value makes the timing observable in simulation. Software changes the configuration words through a single-cycle write port. The status inputs are taken as synchronous to `clk`.

Each pin's stretcher is a four-state machine:
- `S_DARK`: off.
- `S_FULL`: the three-stage register is full.
- `S_TWO`: two stages remain set.
- `S_ONE`: only the last stage remains set.

The transitions are:
- **Load**: from any state to `S_FULL` on a clock edge where the combined indication is high.
- **Drain**: on a tick edge without load, `S_FULL`→`S_TWO`→`S_ONE`→`S_DARK`.
- **Hold**: the state stays the same otherwise.

The pin is lit in every state except `S_DARK`.

Top module: `led_status_top`

## Requirements
- R1: Status bit order is 0 link, 1 receive, 2 transmit, 3 collision, 4 full duplex, 5 100 Mbps speed, 6 receive address match, 7 wake packet. For each pin, the combined indication is the OR over all bits of `status_in & enable`.
- R2: When `wr_en` is high at a clock edge, the word for pin `wr_addr` is updated. `wr_data[7:0]` becomes its enables and `wr_data[8]` its stretch select (1 = stretched). The new word takes effect from the next cycle, and the other pins are unchanged.
- R3: During and after reset, all pins are high (dark) and every pin has stretch select 1. The reset enables are: pin 0 link, pin 1 receive, pin 2 none, pin 3 transmit.
- R4: With stretch select 0, `led_n[i]` equals the inverse of pin i's combined indication in the same cycle.
- R5: With stretch select 1, a clock edge where the combined indication is high makes the pin low from the next cycle.
- R6: In stretched mode, the pin goes high again on the third tick edge after the last edge where the combined indication was high. It never goes high on any edge other than a tick edge.
- R7: When the combined indication is high on a tick edge, the stretcher reloads to full instead of draining.
- R8: The tick is a single-cycle pulse, issued on the clock edge that ends every `TICK_DIV` cycles, counted from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 8 | Network status sources, bit order per R1 |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Pin whose word is written |
| wr_data | input | 9 | Enables [7:0] and stretch select [8] |
| led_n | output | 4 | Active-low indicator pins |

## Verification
The important overlap is a stretcher load and a tick drain falling on the same clock edge. The bench uses its model's tick counter to raise a status bit exactly on the cycle the divider expires, and it checks that the pin stays lit for the whole of three more ticks. A second overlap is a configuration write arriving in the same cycle as status activity for the pin being rewritten. The randomised phase mixes the two freely, and the behavioural model judges every pin on every clock.

// File: rtl/led_pkg.sv
package led_pkg;
    localparam int NUM_SRC = 8;

    localparam int SRC_LINK  = 0;
    localparam int SRC_RX    = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_COL   = 3;
    localparam int SRC_FDX   = 4;
    localparam int SRC_SPD   = 5;
    localparam int SRC_AMTCH = 6;
    localparam int SRC_WAKE  = 7;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     stretch;
        src_vec_t en;
    } led_cfg_t;

    localparam int CFG_W = $bits(led_cfg_t);

    typedef enum logic [1:0] {
        S_DARK = 2'd0,
        S_FULL = 2'd1,
        S_TWO  = 2'd2,
        S_ONE  = 2'd3
    } stretch_state_t;

    function automatic led_cfg_t reset_cfg(input int idx);
        led_cfg_t c;
        c.stretch = 1'b1;
        c.en      = '0;
        case (idx)
            0:       c.en[SRC_LINK] = 1'b1;
            1:       c.en[SRC_RX]   = 1'b1;
            3:       c.en[SRC_TX]   = 1'b1;
            default: c.en           = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int TICK_DIV = 3289474
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_pkg::*;
#(
    parameter int NUM_LED = 4,
    parameter int ADDR_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  led_cfg_t                   wr_data,
    output led_cfg_t [NUM_LED-1:0]     cfg_q
);
    for (genvar i = 0; i < NUM_LED; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= reset_cfg(i);
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                cfg_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/led_stretcher.sv
module led_stretcher
    import led_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic tick,
    output logic lit
);
    stretch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (trig) begin
            state_d = S_FULL;
        end else if (tick) begin
            unique case (state_q)
                S_FULL: state_d = S_TWO;
                S_TWO:  state_d = S_ONE;
                S_ONE:  state_d = S_DARK;
                S_DARK: state_d = S_DARK;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_DARK:                lit = 1'b0;
            S_FULL, S_TWO, S_ONE:  lit = 1'b1;
        endcase
    end
endmodule

// File: rtl/led_status_top.sv
module led_status_top
    import led_pkg::*;
#(
    parameter int NUM_LED  = 4,
    parameter int TICK_DIV = 3289474,
    localparam int ADDR_W  = (NUM_LED > 1) ? $clog2(NUM_LED) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   status_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [NUM_LED-1:0]   led_n
);
    led_cfg_t [NUM_LED-1:0] cfg;
    logic                   tick;
    logic [NUM_LED-1:0]     combined;
    logic [NUM_LED-1:0]     stretch_sel;
    logic [NUM_LED-1:0]     lit;

    led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    led_cfg_regs #(.NUM_LED(NUM_LED), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (led_cfg_t'(wr_data)),
        .cfg_q   (cfg)
    );

    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
        assign combined[i]    = |(status_in & cfg[i].en);
        assign stretch_sel[i] = cfg[i].stretch;

        led_stretcher u_str (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (combined[i]),
            .tick  (tick),
            .lit   (lit[i])
        );

        assign led_n[i] = stretch_sel[i] ? ~lit[i] : ~combined[i];
    end
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
    parameter int NUM_LED  = 4,
    parameter int ADDR_W   = 2,
    parameter int TICK_DIV = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_LED-1:0] led_n,
    input logic [NUM_LED-1:0] combined,
    input logic [NUM_LED-1:0] stretch_sel,
    input logic               tick
);
    for (genvar i = 0; i < NUM_LED; i++) begin : g_pin
        // R4: raw path follows the combined indication, inverted
        a_r4_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !stretch_sel[i] |-> (led_n[i] == !combined[i]));

        // R5: a load lights a stretched pin on the next cycle
        a_r5_load_lights: assert property (@(posedge clk) disable iff (!rst_n)
            (stretch_sel[i] && combined[i] && !(wr_en && wr_addr == ADDR_W'(i)))
            |=> !led_n[i]);

        // R6: a stretched pin only goes dark on a tick edge
        a_r6_dark_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (stretch_sel[i] && $past(stretch_sel[i]) && $rose(led_n[i]))
            |-> $past(tick));
    end

    if (TICK_DIV > 1) begin : g_tick
        // R8: tick lasts one cycle
        a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end
endmodule

bind led_status_top led_status_chk #(
    .NUM_LED  (NUM_LED),
    .ADDR_W   (ADDR_W),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .led_n       (led_n),
    .combined    (combined),
    .stretch_sel (stretch_sel),
    .tick        (tick)
);

// File: tb/led_status_top_bench.sv
`timescale 1ns/1ps
module led_status_top_bench;
    localparam int DIV = 8;
    localparam int NL  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] status_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [3:0] led_n;

    int tests = 0;
    int fails = 0;
    string req = "R3";

    // behavioural reference state
    logic [7:0] m_en [NL];
    bit         m_st [NL];
    int         m_rem [NL];
    int         m_tcnt;

    always #4 clk = ~clk;

    led_status_top #(.NUM_LED(NL), .TICK_DIV(DIV)) u_led_status_top (
        .clk(clk), .rst_n(rst_n), .status_in(status_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .led_n(led_n));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en[0] = 8'h01; m_en[1] = 8'h02; m_en[2] = 8'h00; m_en[3] = 8'h04;
            for (int i = 0; i < NL; i++) begin m_st[i] = 1; m_rem[i] = 0; end
            m_tcnt = 0;
        end else begin
            bit tk;
            tk = (m_tcnt == DIV - 1);
            for (int i = 0; i < NL; i++) begin
                if ((status_in & m_en[i]) != 0) m_rem[i] = 3;
                else if (tk && m_rem[i] > 0) m_rem[i] = m_rem[i] - 1;
            end
            m_tcnt = tk ? 0 : m_tcnt + 1;
            if (wr_en) begin
                m_en[wr_addr] = wr_data[7:0];
                m_st[wr_addr] = wr_data[8];
            end
        end
    end

    task automatic check_pins();
        for (int i = 0; i < NL; i++) begin
            bit comb, exp_n;
            comb  = ((status_in & m_en[i]) != 0);
            exp_n = !(m_st[i] ? (m_rem[i] > 0) : comb);
            tests++;
            if (led_n[i] !== exp_n) begin
                fails++;
                $display("FAIL %s pin%0d led_n got %b expected %b", req, i, led_n[i], exp_n);
            end
        end
    endtask

    task automatic step(input logic [7:0] st, input logic we,
                        input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        check_pins();
        status_in = st; wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(8'h00, 1'b0, 2'd0, 9'h000);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R3: pins dark during reset
        repeat (3) @(negedge clk);
        tests++;
        if (led_n !== 4'hF) begin
            fails++;
            $display("FAIL R3 reset led_n got %h expected %h", led_n, 4'hF);
        end
        rst_n = 1'b1;
        idle(2);

        // R3/R1: reset enables, one source at a time (link, rx, tx, collision)
        req = "R3";
        for (int b = 0; b < 4; b++) begin
            step(8'h01 << b, 1'b0, 2'd0, 9'h000);
            idle(4 * DIV);
        end

        // R5/R6: single pulse on link, stretched drain over three ticks
        req = "R6";
        step(8'h01, 1'b0, 2'd0, 9'h000);
        idle(4 * DIV);
        step(8'h06, 1'b0, 2'd0, 9'h000);
        step(8'h00, 1'b0, 2'd0, 9'h000);
        idle(4 * DIV);

        // R2/R4: pin 2 raw with collision and 100 Mbps speed
        req = "R2";
        step(8'h00, 1'b1, 2'd2, {1'b0, 8'h28});
        req = "R4";
        step(8'h08, 1'b0, 2'd0, 9'h000);
        step(8'h00, 1'b0, 2'd0, 9'h000);
        step(8'h20, 1'b0, 2'd0, 9'h000);
        step(8'h10, 1'b0, 2'd0, 9'h000);
        idle(2);

        // R1/R2: pin 0 stretched on wake packet and address match
        req = "R1";
        step(8'h00, 1'b1, 2'd0, {1'b1, 8'hC0});
        step(8'h40, 1'b0, 2'd0, 9'h000);
        idle(4 * DIV);
        step(8'h80, 1'b0, 2'd0, 9'h000);
        step(8'h01, 1'b0, 2'd0, 9'h000);
        idle(4 * DIV);

        // R7/R8: event coincides with tick edge; reload must win
        req = "R7";
        for (int rep = 0; rep < 3; rep++) begin
            step(8'h02, 1'b0, 2'd0, 9'h000);
            idle(1);
            while (m_tcnt != DIV - 2) idle(1);
            step(8'h02, 1'b0, 2'd0, 9'h000);
            idle(4 * DIV);
        end

        // R2 with overlap: write in same cycle as activity, random mix
        req = "R2";
        for (int c = 0; c < 1500; c++) begin
            logic [7:0] s;
            logic we;
            s  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            we = ($urandom % 40 == 0);
            step(s, we, 2'($urandom), 9'($urandom));
        end
        idle(4 * DIV);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule